// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Access Port

This block gives a byte-wide host bus a window into a packet memory of four pages of 2048 bytes each. The host loads a 16-bit pointer one byte at a time. The pointer's low eleven bits give a byte offset inside a page. Its top bit chooses where the page number comes from: either the page at the head of the receive queue, which arrives on an input, or a packet-number register that the host writes. A second flag bit turns on auto-increment. In that mode every window access advances the offset by one and wraps it inside the page. The remaining pointer bits are left untouched.

The data window is four host addresses, 8 to 11. When auto-increment is off, the pointer stays fixed and the low two bits of the window address are added to the offset. This lets the host reach four consecutive bytes without rewriting the pointer. The packet memory itself sits outside the block as a single-port synchronous RAM. The block drives its address, write-enable, read-enable and write data in the same cycle as the host strobe. Read data, whether from the RAM or from a register, comes back with a valid flag one cycle after the read strobe.

A small response state machine tracks what the host bus returns in each cycle. It has three states:
- `RSP_NONE`: nothing is returned.
- `RSP_REG`: a registered register value is returned.
- `RSP_MEM`: the RAM's read data is returned.

It moves from any state to `RSP_MEM` on a window read and to `RSP_REG` on a read of any other address. On a cycle with no read, or with a write, it moves to `RSP_NONE`.

Top module: `pbp_port`

## Requirements
- R1: After reset the pointer and the packet-number register read as 0, no read data is valid, and no memory strobe is active.
- R2: Host address 1 writes and reads the pointer's low byte, and address 2 writes its high byte. A read of address 2 returns the high byte with bit 3 (pointer bit 11) forced to 0.
- R3: Host address 0 loads the 8-bit packet-number register, and a read returns the stored value.
- R4: On a window access, memory address bits 12:11 are the receive-queue head when pointer bit 15 is 1, and packet-number bits 1:0 when it is 0.
- R5: With pointer bit 14 at 0, a window access at host address 8+k (k = 0..3) uses offset (pointer[10:0] + k) mod 2048 in memory address bits 10:0, and the pointer does not change.
- R6: With pointer bit 14 at 1, a window access uses offset pointer[10:0] whatever k is, and then sets pointer[10:0] to (pointer[10:0] + 1) mod 2048, leaving bits 15:11 unchanged.
- R7: A window write raises mem_we with mem_wdata equal to the host data in the same cycle. A window read raises mem_re in the same cycle, and hst_rdata carries the RAM byte with hst_rvalid high in the next cycle.
- R8: A register read returns its value with hst_rvalid high one cycle later. Addresses 3 to 7 and 12 to 15 read as 0, and writes to them change no register.
- R9: When hst_wr and hst_rd are both high, only the write happens and hst_rvalid stays low in the next cycle. mem_we and mem_re are never high together.
- R10: Accesses to addresses outside 8 to 11 never raise mem_we or mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 4 | Host register address |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid with hst_rvalid |
| hst_rvalid | output | 1 | Read data valid, one cycle after hst_rd |
| rxq_head | input | 2 | Page number at the head of the receive queue |
| mem_addr | output | 13 | Packet memory byte address {page, offset} |
| mem_we | output | 1 | Packet memory write enable |
| mem_re | output | 1 | Packet memory read enable |
| mem_wdata | output | 8 | Packet memory write data |
| mem_rdata | input | 8 | Packet memory read data, one cycle after mem_re |

## Verification
A wrong pointer value shows up in the same cycle as the next window access, as a wrong mem_addr. It also shows up as wrong bytes on a pointer read-back one cycle after the read strobe. A wrong increment or a missing increment is visible on the very next auto-increment access, because that access lands one byte off. A wrong response state shows up in the cycle after a read, as a wrong hst_rvalid or as RAM data where register data belongs. Data written to the wrong place only appears when that location is read back, so reads are mixed in throughout.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_REG  = 2'd1,
        RSP_MEM  = 2'd2
    } rsp_e;

    localparam logic [3:0] ADR_PKTNUM = 4'd0;
    localparam logic [3:0] ADR_PTR_LO = 4'd1;
    localparam logic [3:0] ADR_PTR_HI = 4'd2;
    localparam logic [1:0] WIN_BLOCK  = 2'b10;

    localparam int PTR_W       = 16;
    localparam int PTR_SRC_BIT = 15;
    localparam int PTR_INC_BIT = 14;
    localparam int PTR_HIDE_HI = 3;
endpackage

// File: rtl/pbp_regs.sv
module pbp_regs #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 11,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pkt,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [DATA_W-1:0] pkt_q
);
    localparam int HI_LSB = PTR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            pkt_q <= '0;
        end else begin
            if (wr_pkt) pkt_q <= wdata;
            if (wr_lo)  ptr_q[DATA_W-1:0] <= wdata;
            if (wr_hi)  ptr_q[PTR_W-1:HI_LSB] <= wdata;
            if (step)   ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + 1'b1;
        end
    end
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    parameter int DATA_W     = 8,
    parameter int PTR_W      = 16,
    localparam int PG_W      = $clog2(PAGES),
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic [PTR_W-1:0]      ptr,
    input  logic [DATA_W-1:0]     pkt,
    input  logic [PG_W-1:0]       rxq_head,
    input  logic [1:0]            lane,
    output logic [PG_W+OFS_W-1:0] addr
);
    import pbp_pkg::*;

    logic [PG_W-1:0]  page;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        page = ptr[PTR_SRC_BIT] ? rxq_head : pkt[PG_W-1:0];
        if (ptr[PTR_INC_BIT])
            ofs = ptr[OFS_W-1:0];
        else
            ofs = ptr[OFS_W-1:0] + OFS_W'(lane);
        addr = {page, ofs};
    end
endmodule

// File: rtl/pbp_rsp_fsm.sv
module pbp_rsp_fsm #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_reg,
    input  logic              rd_mem,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    import pbp_pkg::*;

    rsp_e              state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        if (rd_mem)      state_d = RSP_MEM;
        else if (rd_reg) state_d = RSP_REG;
        else             state_d = RSP_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_NONE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_reg) hold_q <= reg_val;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RSP_NONE: ;
            RSP_REG: begin
                rvalid = 1'b1;
                rdata  = hold_q;
            end
            RSP_MEM: begin
                rvalid = 1'b1;
                rdata  = mem_rdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pbp_port.sv
module pbp_port #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    parameter int DATA_W     = 8,
    localparam int PG_W      = $clog2(PAGES),
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int MA_W      = PG_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_rvalid,
    input  logic [PG_W-1:0]   rxq_head,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import pbp_pkg::*;

    logic              win_hit, rd_only, win_acc;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] pkt_q;
    logic [DATA_W-1:0] reg_val;

    always_comb begin
        win_hit = (hst_addr[3:2] == WIN_BLOCK);
        rd_only = hst_rd && !hst_wr;
        win_acc = win_hit && (hst_wr || hst_rd);
        mem_we  = win_hit && hst_wr;
        mem_re  = win_hit && rd_only;
        mem_wdata = hst_wdata;
        unique case (hst_addr)
            ADR_PKTNUM: reg_val = pkt_q;
            ADR_PTR_LO: reg_val = ptr_q[DATA_W-1:0];
            ADR_PTR_HI: begin
                reg_val = ptr_q[PTR_W-1:PTR_W-DATA_W];
                reg_val[PTR_HIDE_HI] = 1'b0;
            end
            default:    reg_val = '0;
        endcase
    end

    pbp_regs #(.DATA_W(DATA_W), .OFS_W(OFS_W), .PTR_W(PTR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_pkt (hst_wr && hst_addr == ADR_PKTNUM),
        .wr_lo  (hst_wr && hst_addr == ADR_PTR_LO),
        .wr_hi  (hst_wr && hst_addr == ADR_PTR_HI),
        .wdata  (hst_wdata),
        .step   (win_acc && ptr_q[PTR_INC_BIT]),
        .ptr_q  (ptr_q),
        .pkt_q  (pkt_q)
    );

    pbp_addr_gen #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_agen (
        .ptr      (ptr_q),
        .pkt      (pkt_q),
        .rxq_head (rxq_head),
        .lane     (hst_addr[1:0]),
        .addr     (mem_addr)
    );

    pbp_rsp_fsm #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_reg    (rd_only && !win_hit),
        .rd_mem    (rd_only && win_hit),
        .reg_val   (reg_val),
        .mem_rdata (mem_rdata),
        .rvalid    (hst_rvalid),
        .rdata     (hst_rdata)
    );
endmodule

// File: rtl/pbp_port_chk.sv
module pbp_port_chk #(
    parameter int PG_W = 2,
    parameter int MA_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      hst_addr,
    input logic            hst_wr,
    input logic            hst_rd,
    input logic            hst_rvalid,
    input logic [PG_W-1:0] rxq_head,
    input logic [MA_W-1:0] mem_addr,
    input logic            mem_we,
    input logic            mem_re,
    input logic [15:0]     ptr_q
);
    localparam int OW = MA_W - PG_W;

    // R9: write and read strobes to memory are exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R7 / R8: a read is answered in the next cycle
    p_rvalid_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && !hst_wr) |=> hst_rvalid);

    // R9: no answer without a plain read
    p_no_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_rd && !hst_wr) |=> !hst_rvalid);

    // R10: memory is only touched through the window
    p_mem_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (hst_addr[3:2] == 2'b10));

    // R4: receive-queue page selection
    p_page_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && ptr_q[15]) |-> (mem_addr[MA_W-1:OW] == rxq_head));

    // R6: auto-increment advances the offset and keeps the upper bits
    p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && ptr_q[14]) |=>
            (ptr_q[OW-1:0] == OW'($past(ptr_q[OW-1:0]) + 1'b1)) &&
            (ptr_q[15:OW] == $past(ptr_q[15:OW])));

    // R5: fixed mode leaves the pointer alone
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !ptr_q[14]) |=> $stable(ptr_q));
endmodule

bind pbp_port pbp_port_chk #(.PG_W(PG_W), .MA_W(MA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_addr   (hst_addr),
    .hst_wr     (hst_wr),
    .hst_rd     (hst_rd),
    .hst_rvalid (hst_rvalid),
    .rxq_head   (rxq_head),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .ptr_q      (ptr_q)
);

// File: tb/sim_pbp_port.sv
`timescale 1ns/1ps
module sim_pbp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        hst_rvalid;
    logic [1:0]  rxq_head = '0;
    logic [12:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  ram    [0:8191];
    logic [7:0]  shadow [0:8191];
    logic [15:0] m_ptr;
    logic [7:0]  m_pkt;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    pbp_port u0 (.*);

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_addr(input logic [1:0] lane);
        logic [10:0] o;
        o = m_ptr[14] ? m_ptr[10:0] : m_ptr[10:0] + 11'(lane);
        return {m_ptr[15] ? rxq_head : m_pkt[1:0], o};
    endfunction

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        #1 check(!mem_we && !mem_re, "R10 reg write strobe", {mem_we, mem_re}, 0);
        @(negedge clk);
        hst_wr = 1'b0;
        if (a == 4'd0) m_pkt = d;
        if (a == 4'd1) m_ptr[7:0] = d;
        if (a == 4'd2) m_ptr[15:8] = d;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        #1 check(!mem_we && !mem_re, "R10 reg read strobe", {mem_we, mem_re}, 0);
        @(negedge clk);
        hst_rd = 1'b0;
        check(hst_rvalid, "R8 rvalid after reg read", hst_rvalid, 1);
        d = hst_rdata;
    endtask

    task automatic chk_regs(input string tag);
        logic [7:0] v;
        reg_rd(4'd0, v); check(v == m_pkt, {tag, " R3 pkt"}, v, m_pkt);
        reg_rd(4'd1, v); check(v == m_ptr[7:0], {tag, " R2 ptr lo"}, v, m_ptr[7:0]);
        reg_rd(4'd2, v); check(v == (m_ptr[15:8] & 8'hF7), {tag, " R2 ptr hi"}, v, m_ptr[15:8] & 8'hF7);
    endtask

    task automatic win(input logic is_wr, input logic [1:0] lane, input logic [7:0] d);
        logic [12:0] ea;
        ea = exp_addr(lane);
        @(negedge clk);
        hst_addr = {2'b10, lane}; hst_wdata = d;
        hst_wr = is_wr; hst_rd = !is_wr;
        #1;
        check(mem_addr == ea, "R4/R5/R6 window address", mem_addr, ea);
        check(mem_we == is_wr && mem_re == !is_wr, "R7 strobes", {mem_we, mem_re}, {is_wr, !is_wr});
        if (is_wr) check(mem_wdata == d, "R7 write data", mem_wdata, d);
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
        if (is_wr) shadow[ea] = d;
        else check(hst_rvalid && hst_rdata == shadow[ea], "R7 window read data", hst_rdata, shadow[ea]);
        if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        reg_wr(4'd1, p[7:0]);
        reg_wr(4'd2, p[15:8]);
    endtask

    initial begin
        #1600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unused;
        unused = $urandom(32'd4711);
        for (int i = 0; i < 8192; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
        mem_rdata = '0;
        m_ptr = '0; m_pkt = '0;
        repeat (3) @(negedge clk);
        #1 check(!hst_rvalid && !mem_we && !mem_re, "R1 reset outputs", {hst_rvalid, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        chk_regs("R1 reset");

        // R2 bit 11 hidden on read-back, R3 full byte stored
        reg_wr(4'd0, 8'hA6);
        set_ptr(16'hFFFF);
        chk_regs("R2 R3 directed");

        // R8 unassigned addresses
        reg_wr(4'd5, 8'h5A);
        reg_wr(4'd13, 8'h11);
        reg_rd(4'd5, v);  check(v == 8'h00, "R8 unassigned read", v, 0);
        reg_rd(4'd14, v); check(v == 8'h00, "R8 unassigned read", v, 0);
        chk_regs("R8 no side effect");

        // R9 read and write together
        @(negedge clk);
        hst_addr = 4'd0; hst_wdata = 8'h3C; hst_wr = 1'b1; hst_rd = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
        m_pkt = 8'h3C;
        check(!hst_rvalid, "R9 no rvalid on write+read", hst_rvalid, 0);
        chk_regs("R9 write wins");

        // R5 fixed-mode wrap inside page, lanes
        reg_wr(4'd0, 8'h02);
        set_ptr(16'h07FE);
        for (int k = 0; k < 4; k++) win(1'b1, 2'(k), 8'h80 + 8'(k));
        for (int k = 0; k < 4; k++) win(1'b0, 2'(k), 8'h00);
        chk_regs("R5 pointer held");

        // R6 increment wrap keeping upper bits, receive-queue page
        rxq_head = 2'd3;
        set_ptr(16'hC7FE);
        for (int k = 0; k < 4; k++) win(1'b1, 2'(3 - k), 8'h40 + 8'(k));
        chk_regs("R6 after wrap");
        set_ptr(16'hC7FE);
        for (int k = 0; k < 4; k++) win(1'b0, 2'(k), 8'h00);
        chk_regs("R6 R4 read pass");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 7) == 0) rxq_head = 2'($urandom);
            case (op)
                0: reg_wr(4'd0, 8'($urandom));
                1: set_ptr({2'($urandom), 3'($urandom), 8'($urandom_range(0, 7)) == 0 ? 11'h7FD : 11'($urandom)});
                2: chk_regs("random");
                3, 4, 5: win(1'b1, 2'($urandom), 8'($urandom));
                default: win(1'b0, 2'($urandom), 8'h00);
            endcase
        end
        chk_regs("final");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule